// File: doc/BRIEF.md
# Burst-of-Two Separate-Port Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with a write data port and a read data port kept apart. Every access moves exactly two data beats. One clock edge marks one beat, and a command slot lasts two beats. A command may be issued only on the first beat of a slot, which is the even beat. The first beat after reset is beat 0. The external word address is one bit narrower than the internal array. The block supplies the low index bit itself: 0 for the first beat and 1 for the second.

A write command is followed by its two data beats on the next two beats. Each data beat carries its own active-low nibble enables. Accepted beats are held in a one-beat write register before they reach the array. A read looks up both words in the beat it is issued. It forwards any nibble that the write register or the data beat on the input holds for the same index. The read data then leaves through a fixed pipeline together with a valid strobe that marks each output beat. The write path and the read path are separate, so a write burst can be arriving while a read burst is leaving.

Top module: `sio_b2_sram`

## Requirements
- R1: Each access covers the two internal words {addr,0} and {addr,1}. Output beat 0 carries word {addr,0} and output beat 1 carries word {addr,1}.
- R2: The write data for the word {addr,0} is on `din` in the beat right after the write command, and the data for {addr,1} is in the beat after that. Each of those beats samples its own `wen_n`: bit 0 low writes bits 3:0 and bit 1 low writes bits 7:4. A high bit leaves that nibble unchanged. `din` and `wen_n` have no effect in any other beat.
- R3: The block samples a command only on even beats, with beat 0 being the first beat after reset. It accepts the command when `ld_n` is 0. `rw_sel` = 1 selects a read and `rw_sel` = 0 selects a write. `ld_n` = 1 on an even beat is a no-operation. `ld_n`, `rw_sel` and `addr` are ignored on odd beats.
- R4: A read accepted on beat n drives `dvalid` high in beats n+3 and n+4, carrying output beat 0 and then output beat 1. At all other times `dvalid` is 0 and `dout` is 0.
- R5: A read in the slot right after a write to the same address returns the newly written nibbles of both words. Nibbles that the write left disabled keep their old contents.
- R6: A read issued in the slot before a write to the same address returns the old contents. A later read returns the new contents.
- R7: Reads in consecutive slots give an unbroken `dvalid` run with the words in command order. Write beats that arrive while a read burst is leaving do not disturb a read to another address.
- R8: A synchronous reset clears `dvalid` and `dout` from the beat after it is sampled. It also drops any read in flight and returns the block to beat 0. A command on the first beat after release is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat clock, one beat per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_n | input | 1 | Command strobe, active low, sampled on even beats |
| rw_sel | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address, one bit narrower than the array index |
| din | input | DATA_W | Write data beat |
| wen_n | input | DATA_W/NIB_W | Active-low nibble enables for the current data beat |
| dout | output | DATA_W | Read data beat, 0 when not valid |
| dvalid | output | 1 | High on each valid read beat |

## Verification
Two functions share the read command beat. In that beat the array lookup for a read runs while the second data beat of the previous write is still on the input, and the first data beat sits in the write register waiting to be committed. The bench provokes this by issuing a read to the same address in the slot right after a write, using full enables and also enables that differ between the two beats. The bench also interleaves writes and reads to different addresses. A behavioural model applies each write to its own array at command time and schedules the expected read beats three beats after the read command. The bench compares `dvalid` and `dout` against that schedule on every beat.

// File: rtl/sio_b2_pkg.sv
`timescale 1ns/1ps
package sio_b2_pkg;

    typedef enum logic {
        PH_CMD = 1'b0,
        PH_DAT = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;

endpackage

// File: rtl/sio_b2_wpath.sv
`timescale 1ns/1ps
module sio_b2_wpath #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4,
    localparam int NIBS  = DATA_W / NIB_W,
    localparam int IDX_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [NIBS-1:0]   wen_n,
    output logic              live_v,
    output logic [IDX_W-1:0]  live_idx,
    output logic [DATA_W-1:0] live_data,
    output logic [NIBS-1:0]   live_en,
    output logic              cm_v,
    output logic [IDX_W-1:0]  cm_idx,
    output logic [DATA_W-1:0] cm_data,
    output logic [NIBS-1:0]   cm_en
);

    typedef struct packed {
        logic [1:0]        slot;
        logic [ADDR_W-1:0] wa;
        logic              cv;
        logic [IDX_W-1:0]  cidx;
        logic [DATA_W-1:0] cdata;
        logic [NIBS-1:0]   cen;
    } wp_st_t;

    wp_st_t st_d, st_q;

    always_comb begin
        live_v    = |st_q.slot;
        live_idx  = {st_q.wa, st_q.slot[1]};
        live_data = din;
        live_en   = ~wen_n;

        st_d       = st_q;
        st_d.slot  = {st_q.slot[0], wr_cmd};
        st_d.wa    = wr_cmd ? addr : st_q.wa;
        st_d.cv    = live_v;
        st_d.cidx  = live_idx;
        st_d.cdata = live_data;
        st_d.cen   = live_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cm_v    = st_q.cv;
    assign cm_idx  = st_q.cidx;
    assign cm_data = st_q.cdata;
    assign cm_en   = st_q.cen;

endmodule

// File: rtl/sio_b2_array.sv
`timescale 1ns/1ps
module sio_b2_array #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4,
    localparam int NIBS  = DATA_W / NIB_W,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              wr_v,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NIBS-1:0]   wr_en,
    input  logic [IDX_W-1:0]  rd_idx0,
    input  logic [IDX_W-1:0]  rd_idx1,
    output logic [DATA_W-1:0] rd_data0,
    output logic [DATA_W-1:0] rd_data1
);

    for (genvar n = 0; n < NIBS; n++) begin : g_lane
        logic [NIB_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_v && wr_en[n]) begin
                mem[wr_idx] <= wr_data[n*NIB_W +: NIB_W];
            end
        end

        assign rd_data0[n*NIB_W +: NIB_W] = mem[rd_idx0];
        assign rd_data1[n*NIB_W +: NIB_W] = mem[rd_idx1];
    end

endmodule

// File: rtl/sio_b2_fwd.sv
`timescale 1ns/1ps
module sio_b2_fwd #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4,
    localparam int NIBS  = DATA_W / NIB_W,
    localparam int IDX_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [DATA_W-1:0] arr0,
    input  logic [DATA_W-1:0] arr1,
    input  logic              cm_v,
    input  logic [IDX_W-1:0]  cm_idx,
    input  logic [DATA_W-1:0] cm_data,
    input  logic [NIBS-1:0]   cm_en,
    input  logic              live_v,
    input  logic [IDX_W-1:0]  live_idx,
    input  logic [DATA_W-1:0] live_data,
    input  logic [NIBS-1:0]   live_en,
    output logic [DATA_W-1:0] word0,
    output logic [DATA_W-1:0] word1
);

    logic [1:0][DATA_W-1:0] merged;

    for (genvar w = 0; w < 2; w++) begin : g_word
        logic [IDX_W-1:0]  widx;
        logic [DATA_W-1:0] base;

        assign widx = {rd_base, (w == 1)};
        assign base = (w == 1) ? arr1 : arr0;

        for (genvar n = 0; n < NIBS; n++) begin : g_nib
            logic [NIB_W-1:0] nib;

            // the live beat is newer than the registered one, so it wins
            always_comb begin
                nib = base[n*NIB_W +: NIB_W];
                if (cm_v && cm_en[n] && (cm_idx == widx)) begin
                    nib = cm_data[n*NIB_W +: NIB_W];
                end
                if (live_v && live_en[n] && (live_idx == widx)) begin
                    nib = live_data[n*NIB_W +: NIB_W];
                end
            end

            assign merged[w][n*NIB_W +: NIB_W] = nib;
        end
    end

    assign word0 = merged[0];
    assign word1 = merged[1];

endmodule

// File: rtl/sio_b2_rpipe.sv
`timescale 1ns/1ps
module sio_b2_rpipe #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_cmd,
    input  logic [DATA_W-1:0] word0,
    input  logic [DATA_W-1:0] word1,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);

    typedef struct packed {
        logic              s1v;
        logic [DATA_W-1:0] s1w0;
        logic [DATA_W-1:0] s1w1;
        logic              s2v;
        logic [DATA_W-1:0] s2w0;
        logic [DATA_W-1:0] s2w1;
        logic              s3v;
        logic [DATA_W-1:0] s3w1;
        logic              ov;
        logic [DATA_W-1:0] od;
    } rp_st_t;

    rp_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1v  = rd_cmd;
        st_d.s1w0 = word0;
        st_d.s1w1 = word1;
        st_d.s2v  = st_q.s1v;
        st_d.s2w0 = st_q.s1w0;
        st_d.s2w1 = st_q.s1w1;
        st_d.s3v  = st_q.s2v;
        st_d.s3w1 = st_q.s2w1;
        st_d.ov   = st_q.s2v | st_q.s3v;
        if (st_q.s2v) begin
            st_d.od = st_q.s2w0;
        end else if (st_q.s3v) begin
            st_d.od = st_q.s3w1;
        end else begin
            st_d.od = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout   = st_q.od;
    assign dvalid = st_q.ov;

endmodule

// File: rtl/sio_b2_sram.sv
`timescale 1ns/1ps
module sio_b2_sram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4,
    localparam int NIBS  = DATA_W / NIB_W,
    localparam int IDX_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              rw_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [NIBS-1:0]   wen_n,
    output logic [DATA_W-1:0] dout,
    output logic              dvalid
);
    import sio_b2_pkg::*;

    typedef struct packed {
        phase_e ph;
    } top_st_t;

    top_st_t st_d, st_q;
    cmd_e    cmd;

    logic              rd_cmd, wr_cmd;
    logic              live_v, cm_v;
    logic [IDX_W-1:0]  live_idx, cm_idx;
    logic [DATA_W-1:0] live_data, cm_data;
    logic [NIBS-1:0]   live_en, cm_en;
    logic [DATA_W-1:0] arr0, arr1, word0, word1;

    always_comb begin
        st_d.ph = (st_q.ph == PH_CMD) ? PH_DAT : PH_CMD;
        if (st_q.ph == PH_CMD && !ld_n) begin
            cmd = rw_sel ? CMD_RD : CMD_WR;
        end else begin
            cmd = CMD_NONE;
        end
        rd_cmd = (cmd == CMD_RD);
        wr_cmd = (cmd == CMD_WR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ph: PH_CMD};
        end else begin
            st_q <= st_d;
        end
    end

    sio_b2_wpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIB_W(NIB_W)) u_wp (
        .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .addr(addr), .din(din), .wen_n(wen_n),
        .live_v(live_v), .live_idx(live_idx), .live_data(live_data), .live_en(live_en),
        .cm_v(cm_v), .cm_idx(cm_idx), .cm_data(cm_data), .cm_en(cm_en)
    );

    sio_b2_array #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NIB_W(NIB_W)) u_arr (
        .clk(clk), .wr_v(cm_v), .wr_idx(cm_idx), .wr_data(cm_data), .wr_en(cm_en),
        .rd_idx0({addr, 1'b0}), .rd_idx1({addr, 1'b1}),
        .rd_data0(arr0), .rd_data1(arr1)
    );

    sio_b2_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIB_W(NIB_W)) u_fwd (
        .rd_base(addr), .arr0(arr0), .arr1(arr1),
        .cm_v(cm_v), .cm_idx(cm_idx), .cm_data(cm_data), .cm_en(cm_en),
        .live_v(live_v), .live_idx(live_idx), .live_data(live_data), .live_en(live_en),
        .word0(word0), .word1(word1)
    );

    sio_b2_rpipe #(.DATA_W(DATA_W)) u_rp (
        .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .word0(word0), .word1(word1),
        .dout(dout), .dvalid(dvalid)
    );

endmodule

// File: rtl/sio_b2_chk.sv
`timescale 1ns/1ps
module sio_b2_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_n,
    input logic              rw_sel,
    input logic              live_v,
    input logic              dvalid,
    input logic [DATA_W-1:0] dout
);

    logic       ph_q;
    logic [3:0] rsh_q;
    logic [1:0] wsh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= 1'b0;
            rsh_q <= '0;
            wsh_q <= '0;
        end else begin
            ph_q  <= ~ph_q;
            rsh_q <= {rsh_q[2:0], (!ph_q && !ld_n && rw_sel)};
            wsh_q <= {wsh_q[0], (!ph_q && !ld_n && !rw_sel)};
        end
    end

    // R4
    valid_align_chk: assert property (@(posedge clk) disable iff (rst)
        dvalid == (rsh_q[2] | rsh_q[3]));

    // R4
    dout_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !dvalid |-> dout == '0);

    // R1
    burst_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dvalid) |=> dvalid);

    // R2
    wbeat_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wsh_q[0] | wsh_q[1]) |-> live_v);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!dvalid && dout == '0));

endmodule

bind sio_b2_sram sio_b2_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel),
    .live_v(live_v), .dvalid(dvalid), .dout(dout)
);

// File: tb/sio_b2_sram_test.sv
`timescale 1ns/1ps
module sio_b2_sram_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_n = 1'b1;
    logic       rw_sel = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] din = '0;
    logic [1:0] wen_n = 2'b11;
    logic [7:0] dout;
    logic       dvalid;

    sio_b2_sram uut (
        .clk(clk), .rst(rst), .ld_n(ld_n), .rw_sel(rw_sel), .addr(addr),
        .din(din), .wen_n(wen_n), .dout(dout), .dvalid(dvalid)
    );

    always #2.5 clk = ~clk;

    int    errs = 0, checks = 0, t = 0;
    bit    done = 0, nowait = 0;
    string req = "R8";
    logic [7:0] mref [32];
    bit         exp_v [8];
    logic [7:0] exp_d [8];
    bit         sv [4];
    logic [7:0] sd [4];
    logic [1:0] se [4];

    function automatic logic [7:0] mrg(logic [7:0] old, logic [7:0] nw, logic [1:0] e_n);
        mrg = old;
        if (!e_n[0]) mrg[3:0] = nw[3:0];
        if (!e_n[1]) mrg[7:4] = nw[7:4];
    endfunction

    task automatic chk_out(bit ev, logic [7:0] ed);
        checks++;
        if (dvalid !== ev || dout !== ed) begin
            errs++;
            $display("FAIL %s beat %0d: dvalid=%b dout=%h expected dvalid=%b dout=%h",
                     req, t, dvalid, dout, ev, ed);
        end
    endtask

    task automatic clear_ring();
        for (int i = 0; i < 8; i++) begin exp_v[i] = 0; exp_d[i] = 8'h00; end
        for (int i = 0; i < 4; i++) sv[i] = 0;
    endtask

    task automatic beat(logic l, logic r, logic [3:0] a);
        if (!nowait) @(negedge clk);
        nowait = 0;
        chk_out(exp_v[t%8], exp_d[t%8]);
        exp_v[t%8] = 0; exp_d[t%8] = 8'h00;
        ld_n = l; rw_sel = r; addr = a;
        if (sv[t%4]) begin din = sd[t%4]; wen_n = se[t%4]; sv[t%4] = 0; end
        else begin din = 8'hEE; wen_n = 2'b00; end
        if (t % 2 == 0 && !l && r) begin
            exp_v[(t+3)%8] = 1; exp_d[(t+3)%8] = mref[{a, 1'b0}];
            exp_v[(t+4)%8] = 1; exp_d[(t+4)%8] = mref[{a, 1'b1}];
        end
        t++;
    endtask

    task automatic odd_beat(bit noise, logic [3:0] a);
        if (noise) beat(1'b0, a[0], ~a);
        else       beat(1'b1, 1'b0, a);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d0, logic [1:0] e0,
                      logic [7:0] d1, logic [1:0] e1, bit noise = 0);
        sv[(t+1)%4] = 1; sd[(t+1)%4] = d0; se[(t+1)%4] = e0;
        sv[(t+2)%4] = 1; sd[(t+2)%4] = d1; se[(t+2)%4] = e1;
        mref[{a, 1'b0}] = mrg(mref[{a, 1'b0}], d0, e0);
        mref[{a, 1'b1}] = mrg(mref[{a, 1'b1}], d1, e1);
        beat(1'b0, 1'b0, a);
        odd_beat(noise, a);
    endtask

    task automatic rd(logic [3:0] a, bit noise = 0);
        beat(1'b0, 1'b1, a);
        odd_beat(noise, a);
    endtask

    task automatic nop(bit noise = 0, logic [3:0] a = 4'h0);
        beat(1'b1, a[1], a);
        odd_beat(noise, a);
    endtask

    task automatic do_reset(int n);
        @(negedge clk);
        rst = 1; ld_n = 1;
        req = "R8";
        repeat (n) begin
            @(negedge clk);
            chk_out(1'b0, 8'h00);
        end
        clear_ring();
        rst = 0; t = 0; nowait = 1;
    endtask

    initial begin
        clear_ring();
        do_reset(3);

        // R2: fill the array with full enables, back to back
        req = "R2";
        for (int a = 0; a < 16; a++) begin
            wr(4'(a), 8'(a * 7 + 1), 2'b00, ~8'(a * 7 + 1), 2'b00);
        end
        // R1 / R4: read every address, back to back
        req = "R1";
        for (int a = 0; a < 16; a++) rd(4'(a));
        req = "R4";
        nop(); nop(); nop();

        // R5: read right after a write to the same address
        req = "R5";
        wr(4'd5, 8'h5A, 2'b00, 8'hC3, 2'b00);
        rd(4'd5);
        wr(4'd6, 8'h9B, 2'b10, 8'h71, 2'b01);
        rd(4'd6);
        nop(); nop();

        // R2: all enables high leaves both words unchanged
        req = "R2";
        wr(4'd7, 8'h00, 2'b11, 8'hFF, 2'b11);
        rd(4'd7);
        nop(); nop();

        // R6: read before a write to the same address
        req = "R6";
        rd(4'd8);
        wr(4'd8, 8'h12, 2'b00, 8'h34, 2'b00);
        rd(4'd8);
        nop(); nop();

        // R7: write beats in flight while reads leave
        req = "R7";
        wr(4'd9, 8'hA1, 2'b00, 8'hB2, 2'b00);
        rd(4'd3);
        wr(4'd10, 8'hC4, 2'b01, 8'hD5, 2'b10);
        rd(4'd9);
        rd(4'd10);
        rd(4'd3);
        nop(); nop(); nop();

        // R3: odd-beat commands and high ld_n are ignored
        req = "R3";
        nop(1'b1, 4'd2);
        nop(1'b1, 4'd11);
        wr(4'd12, 8'h66, 2'b00, 8'h77, 2'b00, 1'b1);
        rd(4'd13, 1'b1);
        nop(1'b1, 4'd4);
        rd(4'd12);
        rd(4'd13);
        rd(4'd2);
        rd(4'd11);
        nop(); nop(); nop();

        // R8: reset in the middle of a read burst
        rd(4'd1);
        do_reset(3);
        req = "R8";
        wr(4'd14, 8'h3E, 2'b00, 8'h4F, 2'b00);
        rd(4'd14);
        nop(); nop(); nop();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks + 1);
            $finish;
        end
    end

endmodule